// File: doc/BRIEF.md
# Burst Address Generator

This block works out the byte address of every beat in one AXI read or write burst. A start strobe captures four things: the first address, the beat count minus one, the log2 of the bytes per beat, and the burst kind. The generator then presents the first beat's address. Each pulse on the advance strobe stands for one accepted data beat and moves the output to the next address. A flag marks the final beat.

Three sequences are supported:
- **Fixed:** every beat reuses the first address.
- **Incrementing:** each beat steps by the beat size.
- **Wrapping:** addresses climb like an incrementing burst, but fall back to the bottom of an aligned window when they pass its top.

The block also checks each burst when it starts. A burst that breaks the rules raises an error flag and produces no beats. Illegal cases are a reserved kind code, a malformed wrapping burst, and an incrementing burst that would leave its 4 KB page.

The owner of the data channel drives the advance strobe when a beat is accepted. It reads `addr_o` and `last_o` in that same cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr_o` is 0, `last_o` is 0 and `err_o` is 0.
- R2: In the cycle after `start_i`, `addr_o` equals the captured `addr_i` and the beat counter is back at beat 0. `start_i` takes priority over `advance_i` and over a burst already in progress.
- R3: A legal burst has `len_i`+1 beats. `last_o` is high exactly while the current beat is beat `len_i`. An advance on that beat ends the burst, after which `last_o` stays low.
- R4: With kind code 2'b00 (fixed), every beat's address equals the start address.
- R5: With kind code 2'b01 (incrementing), each beat's address is the previous one plus 2^`size_i` bytes.
- R6: With kind code 2'b10 (wrapping), the window is (`len_i`+1)·2^`size_i` bytes and starts at the start address rounded down to that size. The address steps by 2^`size_i`, and a step that would leave the window goes to the window's lowest address.
- R7: Kind code 2'b11 is reserved. Starting with it sets `err_o`.
- R8: A wrapping burst sets `err_o` unless `len_i` is 1, 3, 7 or 15 and `addr_i` is a multiple of 2^`size_i`.
- R9: An incrementing burst sets `err_o` when its first byte and its last byte (start + (`len_i`+1)·2^`size_i` − 1) lie in different 4 KB pages (differing address bits 31:12). A fixed burst never sets `err_o`.
- R10: After a rejected start, `last_o` stays low and `advance_i` is ignored. `addr_o` keeps the start address and `err_o` stays high until the next `start_i`. A legal start clears `err_o`.
- R11: While `advance_i` is low, or no burst is active, `addr_o` and `last_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture a new burst description |
| advance_i | input | 1 | Current beat accepted; step to the next |
| addr_i | input | 32 | First byte address of the burst |
| len_i | input | 4 | Beats minus one |
| size_i | input | 3 | log2 of bytes per beat |
| kind_i | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| addr_o | output | 32 | Address of the current beat |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Last started burst was rejected |

## Verification
The embedded properties assume the following about the inputs:
- `advance_i` is only meaningful while a burst is active.
- `start_i` may arrive at any time, including mid-burst and together with `advance_i`.
- `size_i` and `len_i` take any value, so a wrapping window can span up to 2 KB.

The stimulus sweeps every kind, every length and every size over start addresses chosen to hit the following cases:
- page-aligned addresses
- addresses just below a page end
- misaligned addresses
- addresses in the middle of a window

Beats are interleaved with idle cycles. A restart arriving together with an advance is applied once, in the middle of a burst.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_RSVD  = 2'b11
  } burst_kind_e;

endpackage

// File: rtl/burst_legal_chk.sv
module burst_legal_chk
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 4,
  parameter int SIZE_W         = 3,
  parameter int PAGE_BITS      = 12,
  parameter int MAX_WRAP_BEATS = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  input  burst_kind_e       kind_i,
  output logic              illegal_o
);

  localparam int PAGE_HI = ADDR_W - 1;

  logic [ADDR_W-1:0] beats_w;
  logic [ADDR_W-1:0] span_w;
  logic [ADDR_W-1:0] last_byte;
  logic [ADDR_W-1:0] size_mask;
  logic              page_cross;
  logic              wrap_len_ok;
  logic              wrap_align_ok;

  always_comb begin
    beats_w       = ADDR_W'(len_i) + ADDR_W'(1);
    span_w        = beats_w << size_i;
    last_byte     = addr_i + span_w - ADDR_W'(1);
    page_cross    = addr_i[PAGE_HI:PAGE_BITS] != last_byte[PAGE_HI:PAGE_BITS];
    size_mask     = (ADDR_W'(1) << size_i) - ADDR_W'(1);
    wrap_align_ok = (addr_i & size_mask) == '0;
    wrap_len_ok   = (len_i != '0)
                  && ((beats_w & (beats_w - ADDR_W'(1))) == '0)
                  && (beats_w <= ADDR_W'(MAX_WRAP_BEATS));
    unique case (kind_i)
      BK_FIXED: illegal_o = 1'b0;
      BK_INCR:  illegal_o = page_cross;
      BK_WRAP:  illegal_o = !(wrap_len_ok && wrap_align_ok);
      default:  illegal_o = 1'b1;
    endcase
  end

  always_comb begin
    if (kind_i == BK_FIXED) begin
      AST_FIXED_ALWAYS_LEGAL: assert (!illegal_o); // R9
    end
  end

endmodule

// File: rtl/burst_step_calc.sv
module burst_step_calc
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  input  burst_kind_e       kind_i,
  output logic [ADDR_W-1:0] nxt_addr_o
);

  logic [ADDR_W-1:0] step_w;
  logic [ADDR_W-1:0] incr_addr;
  logic [ADDR_W-1:0] win_mask;
  logic [ADDR_W-1:0] wrap_addr;

  always_comb begin
    step_w    = ADDR_W'(1) << size_i;
    incr_addr = cur_addr_i + step_w;
    win_mask  = ((ADDR_W'(len_i) + ADDR_W'(1)) << size_i) - ADDR_W'(1);
    wrap_addr = (cur_addr_i & ~win_mask) | (incr_addr & win_mask);
    unique case (kind_i)
      BK_INCR: nxt_addr_o = incr_addr;
      BK_WRAP: nxt_addr_o = wrap_addr;
      default: nxt_addr_o = cur_addr_i;
    endcase
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             at_end_o
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear_i || step_i;
    cnt_d  = clear_i ? '0 : cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign at_end_o = cnt_q == len_i;

  AST_BEAT_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= len_i); // R3

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 4,
  parameter int SIZE_W    = 3,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              advance_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        kind_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              err_o
);

  burst_kind_e       kind_in;
  burst_kind_e       kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d, nxt_addr;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic              active_q, active_d;
  logic              err_q, err_d;
  logic              illegal;
  logic              at_end;
  logic              beat_step;
  logic              desc_en;

  assign kind_in = burst_kind_e'(kind_i);

  burst_legal_chk #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .SIZE_W   (SIZE_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_legal (
    .addr_i   (addr_i),
    .len_i    (len_i),
    .size_i   (size_i),
    .kind_i   (kind_in),
    .illegal_o(illegal)
  );

  burst_step_calc #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .SIZE_W(SIZE_W)
  ) u_step (
    .cur_addr_i(addr_q),
    .len_i     (len_q),
    .size_i    (size_q),
    .kind_i    (kind_q),
    .nxt_addr_o(nxt_addr)
  );

  assign beat_step = advance_i && active_q && !at_end && !start_i;

  burst_beat_ctr #(
    .LEN_W(LEN_W)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i),
    .step_i  (beat_step),
    .len_i   (len_q),
    .at_end_o(at_end)
  );

  // next-state
  always_comb begin
    desc_en  = start_i;
    len_d    = len_i;
    size_d   = size_i;
    kind_d   = kind_in;
    addr_d   = addr_q;
    active_d = active_q;
    err_d    = err_q;
    if (start_i) begin
      addr_d   = addr_i;
      err_d    = illegal;
      active_d = !illegal;
    end else if (advance_i && active_q) begin
      if (at_end) begin
        active_d = 1'b0;
      end else begin
        addr_d = nxt_addr;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      active_q <= active_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      size_q <= '0;
      kind_q <= BK_FIXED;
    end else if (desc_en) begin
      len_q  <= len_d;
      size_q <= size_d;
      kind_q <= kind_d;
    end
  end

  assign addr_o = addr_q;
  assign last_o = active_q && at_end;
  assign err_o  = err_q;

  // checking aids
  logic              mid_step;
  logic [ADDR_W-1:0] beat_bytes;
  logic [ADDR_W-1:0] win_lo_mask;
  assign mid_step    = advance_i && active_q && !start_i && !last_o;
  assign beat_bytes  = ADDR_W'(1) << size_q;
  assign win_lo_mask = ~(((ADDR_W'(len_q) + ADDR_W'(1)) << size_q) - ADDR_W'(1));

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> addr_o == $past(addr_i)); // R2
  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_step && kind_q == BK_FIXED) |=> $stable(addr_o)); // R4
  AST_INCR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_step && kind_q == BK_INCR) |=> addr_o == $past(addr_o) + $past(beat_bytes)); // R5
  AST_INCR_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_step && kind_q == BK_INCR) |=> $stable(addr_o[ADDR_W-1:PAGE_BITS])); // R9
  AST_WRAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_step && kind_q == BK_WRAP) |=> (addr_o & win_lo_mask) == $past(addr_o & win_lo_mask)); // R6
  AST_REJECT_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !last_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !(advance_i && active_q)) |=> $stable(addr_o) && $stable(last_o)); // R11

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        adv = 1'b0;
  logic [31:0] a_in = '0;
  logic [3:0]  l_in = '0;
  logic [2:0]  s_in = '0;
  logic [1:0]  k_in = '0;
  logic [31:0] addr_o;
  logic        last_o;
  logic        err_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .advance_i(adv),
    .addr_i   (a_in),
    .len_i    (l_in),
    .size_i   (s_in),
    .kind_i   (k_in),
    .addr_o   (addr_o),
    .last_o   (last_o),
    .err_o    (err_o)
  );

  task automatic check(bit ok, string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit model_err(longint unsigned a, int l, int s, int k);
    longint unsigned span = longint'(l + 1) << s;
    case (k)
      0: return 1'b0;
      1: return ((a + span - 1) >> 12) != (a >> 12);
      2: return !((l == 1 || l == 3 || l == 7 || l == 15) && (a % (longint'(1) << s)) == 0);
      default: return 1'b1;
    endcase
  endfunction

  function automatic longint unsigned model_addr(longint unsigned a, int l, int s, int k, int b);
    longint unsigned span = longint'(l + 1) << s;
    longint unsigned low;
    case (k)
      0: return a;
      1: return (a + (longint'(b) << s)) & 64'hFFFF_FFFF;
      default: begin
        low = (a / span) * span;
        return low + ((a - low + (longint'(b) << s)) % span);
      end
    endcase
  endfunction

  function automatic string kind_tag(int k);
    case (k)
      0: return "R4";
      1: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic string err_tag(int k);
    case (k)
      0: return "R9";
      1: return "R9";
      2: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic run_burst(logic [31:0] a, int l, int s, int k, int gap_sel);
    bit e;
    longint unsigned ex;
    @(negedge clk);
    a_in = a; l_in = 4'(l); s_in = 3'(s); k_in = 2'(k);
    start = 1'b1;
    adv = (gap_sel == 1);   // start must win over advance (R2)
    @(negedge clk);
    start = 1'b0; adv = 1'b0;
    e = model_err(a, l, s, k);
    check(err_o == e, err_tag(k), err_o, e);
    check(addr_o == a, "R2", addr_o, a);
    if (e) begin
      check(last_o == 1'b0, "R10", last_o, 0);
      adv = 1'b1;
      @(negedge clk);
      adv = 1'b0;
      check(addr_o == a && last_o == 1'b0 && err_o == 1'b1, "R10", addr_o, a);
      return;
    end
    for (int b = 0; b <= l; b++) begin
      ex = model_addr(a, l, s, k, b);
      check(addr_o == ex[31:0], kind_tag(k), addr_o, ex);
      check(last_o == (b == l), "R3", last_o, (b == l));
      if ((b % 3) == gap_sel) begin
        @(negedge clk);
        check(addr_o == ex[31:0] && last_o == (b == l), "R11", addr_o, ex);
      end
      adv = 1'b1;
      @(negedge clk);
      adv = 1'b0;
    end
    check(last_o == 1'b0, "R3", last_o, 0);
    check(err_o == 1'b0, "R10", err_o, 0);
    ex = model_addr(a, l, s, k, l);
    adv = 1'b1;
    @(negedge clk);
    adv = 1'b0;
    check(addr_o == ex[31:0] && last_o == 1'b0, "R11", addr_o, ex);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] starts [6];
    starts[0] = 32'h0000_1000;
    starts[1] = 32'h0000_1FF0;
    starts[2] = 32'h0000_2004;
    starts[3] = 32'h0000_3F83;
    starts[4] = 32'h0ABC_0E40;
    starts[5] = 32'h0000_0FFC;

    repeat (3) @(negedge clk);
    check(addr_o == 0 && last_o == 0 && err_o == 0, "R1", {addr_o, last_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(addr_o == 0 && last_o == 0 && err_o == 0, "R1", {addr_o, last_o, err_o}, 0);

    for (int i = 0; i < 6; i++)
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < 8; s++)
          for (int l = 0; l < 16; l++)
            run_burst(starts[i], l, s, k, (i + l + s) % 3);

    // restart in the middle of an incrementing burst, together with an advance
    @(negedge clk);
    a_in = 32'h100; l_in = 4'd7; s_in = 3'd2; k_in = 2'b01; start = 1'b1;
    @(negedge clk);
    start = 1'b0; adv = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(addr_o == 32'h108, "R5", addr_o, 32'h108);
    a_in = 32'h0000_0770; l_in = 4'd0; s_in = 3'd0; k_in = 2'b00; start = 1'b1; adv = 1'b1;
    @(negedge clk);
    start = 1'b0; adv = 1'b0;
    check(addr_o == 32'h770, "R2", addr_o, 32'h770);
    check(last_o == 1'b1, "R2", last_o, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule